// File: doc/BRIEF.md
# PTP Time-of-Day Clock Engine

This block keeps the running time of day for precision time work as a seconds count and a nanoseconds count. It runs from a 125 MHz timebase, so time advances by about 8 ns per clock. Other blocks, such as timestamp units and event generators, read the current time from its outputs in every cycle.

The per-cycle increment has an integer nanosecond part and a 32-bit binary fraction. A fraction accumulator carries into the nanosecond count, so software can trim the rate with very fine resolution. A servo running in software steers the clock through three independent strobed controls. The first loads an absolute time. The second shifts the running time by a signed number of nanoseconds in a single cycle. The third replaces the increment word.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset both time outputs are zero, the fraction accumulator is zero and the increment is exactly 8.0 ns, so with no strobes the nanosecond output reads 8·k after k clocks.
- R2: The nanosecond output never reaches 1,000,000,000. When counting passes that value, the excess remains in the nanosecond output and the seconds output rises by one.
- R3: In each clock the time advances by the integer increment plus the carry out of a 32-bit fraction accumulator. That accumulator adds the fractional increment (units of 2^-32 ns) every clock. For example, 7.5 ns gives alternating steps of 7 and 8.
- R4: With `set_load` high and `set_ns` below 1,000,000,000, the next clock makes the outputs equal `set_sec`/`set_ns` exactly, with no increment added, and clears the fraction accumulator.
- R5: A `set_load` whose `set_ns` is 1,000,000,000 or more is ignored. Time keeps counting as if the strobe were absent, and any offset in the same cycle still applies.
- R6: With `adj_load` high, the next time equals the current time plus the normal step plus the signed offset `adj_ns` (two's complement, in ns). A negative result borrows one second and a result of one second or more carries one second.
- R7: When a valid load and an offset arrive in the same clock, the load wins and the offset is discarded.
- R8: `rate_load` replaces the increment with `rate_int`/`rate_frac`. The step taken on that same clock still uses the old increment, and the new one applies from the next clock on.
- R9: The seconds output wraps from 2^48−1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_load | input | 1 | Strobe: load absolute time |
| set_sec | input | 48 | Seconds value to load |
| set_ns | input | 30 | Nanoseconds value to load |
| adj_load | input | 1 | Strobe: apply signed offset |
| adj_ns | input | 30 | Signed offset in ns, two's complement |
| rate_load | input | 1 | Strobe: replace increment |
| rate_int | input | 4 | Integer ns part of new increment |
| rate_frac | input | 32 | Fraction part of new increment (2^-32 ns units) |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
Four properties are checked on every cycle. The nanosecond output must stay below one second. A valid load must land exactly. A valid load must win over an offset in the same cycle. Without strobes, seconds may only hold or step by one, and when they step the nanoseconds must fall back. Only the bench's scenarios can show the exact stepping pattern of a fractional increment, the one-cycle delay of a rate change, the borrow across seconds after a negative offset, the dropping of an out-of-range load and the wrap of the seconds field. The bench compares every cycle against its own model of these rules.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam int unsigned NS_PER_SEC = 32'd1_000_000_000;

    typedef enum logic [1:0] {
        NORM_KEEP   = 2'd0,
        NORM_BORROW = 2'd1,
        NORM_CARRY  = 2'd2
    } norm_e;

endpackage

// File: rtl/ptp_frac_acc.sv
module ptp_frac_acc #(
    parameter int FRAC_W = 32,
    parameter int INC_W  = 4
) (
    input  logic [FRAC_W-1:0] acc_in,
    input  logic [FRAC_W-1:0] inc_frac,
    input  logic [INC_W-1:0]  inc_int,
    output logic [FRAC_W-1:0] acc_out,
    output logic [INC_W:0]    step_ns
);
    logic [FRAC_W:0] sum;

    always_comb begin
        sum     = {1'b0, acc_in} + {1'b0, inc_frac};
        acc_out = sum[FRAC_W-1:0];
        step_ns = {1'b0, inc_int} + {{INC_W{1'b0}}, sum[FRAC_W]};
    end
endmodule

// File: rtl/ptp_ns_norm.sv
module ptp_ns_norm #(
    parameter int SEC_W  = 48,
    parameter int NS_W   = 30,
    parameter int STEP_W = 5,
    parameter int ADJ_W  = 30
) (
    input  logic [SEC_W-1:0]        sec_in,
    input  logic [NS_W-1:0]         ns_in,
    input  logic [STEP_W-1:0]       step,
    input  logic                    adj_en,
    input  logic signed [ADJ_W-1:0] adj,
    output logic [SEC_W-1:0]        sec_out,
    output logic [NS_W-1:0]         ns_out,
    output ptp_tod_pkg::norm_e      kind
);
    localparam int SUM_W = NS_W + 2;
    localparam logic signed [SUM_W-1:0] NPS = SUM_W'(ptp_tod_pkg::NS_PER_SEC);

    logic signed [SUM_W-1:0] adj_x;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] fixed;

    always_comb begin
        adj_x = adj_en ? SUM_W'(adj) : '0;
        sum   = $signed({2'b00, ns_in})
              + $signed({{(SUM_W-STEP_W){1'b0}}, step})
              + adj_x;
        if (sum < 0) begin
            fixed   = sum + NPS;
            sec_out = sec_in - 1'b1;
            kind    = ptp_tod_pkg::NORM_BORROW;
        end else if (sum >= NPS) begin
            fixed   = sum - NPS;
            sec_out = sec_in + 1'b1;
            kind    = ptp_tod_pkg::NORM_CARRY;
        end else begin
            fixed   = sum;
            sec_out = sec_in;
            kind    = ptp_tod_pkg::NORM_KEEP;
        end
        ns_out = fixed[NS_W-1:0];
    end
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock #(
    parameter int SEC_W      = 48,
    parameter int NS_W       = 30,
    parameter int INC_W      = 4,
    parameter int FRAC_W     = 32,
    parameter int ADJ_W      = 30,
    parameter int RST_INC_NS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_load,
    input  logic [SEC_W-1:0]        set_sec,
    input  logic [NS_W-1:0]         set_ns,
    input  logic                    adj_load,
    input  logic signed [ADJ_W-1:0] adj_ns,
    input  logic                    rate_load,
    input  logic [INC_W-1:0]        rate_int,
    input  logic [FRAC_W-1:0]       rate_frac,
    output logic [SEC_W-1:0]        tod_sec,
    output logic [NS_W-1:0]         tod_ns
);
    localparam int STEP_W = INC_W + 1;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
        logic [INC_W-1:0]  inc_int;
        logic [FRAC_W-1:0] inc_frac;
    } tod_state_t;

    tod_state_t st_d, st_q;

    logic [FRAC_W-1:0]  acc_next;
    logic [STEP_W-1:0]  step_ns;
    logic [SEC_W-1:0]   run_sec;
    logic [NS_W-1:0]    run_ns;
    ptp_tod_pkg::norm_e run_kind;
    logic               set_ok;

    ptp_frac_acc #(.FRAC_W(FRAC_W), .INC_W(INC_W)) u_acc (
        .acc_in   (st_q.frac),
        .inc_frac (st_q.inc_frac),
        .inc_int  (st_q.inc_int),
        .acc_out  (acc_next),
        .step_ns  (step_ns)
    );

    ptp_ns_norm #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W), .ADJ_W(ADJ_W)) u_norm (
        .sec_in  (st_q.sec),
        .ns_in   (st_q.ns),
        .step    (step_ns),
        .adj_en  (adj_load),
        .adj     (adj_ns),
        .sec_out (run_sec),
        .ns_out  (run_ns),
        .kind    (run_kind)
    );

    always_comb begin
        st_d   = st_q;
        set_ok = set_load && (32'(set_ns) < ptp_tod_pkg::NS_PER_SEC);
        if (set_ok) begin
            st_d.sec  = set_sec;
            st_d.ns   = set_ns;
            st_d.frac = '0;
        end else begin
            st_d.sec  = run_sec;
            st_d.ns   = run_ns;
            st_d.frac = acc_next;
        end
        if (rate_load) begin
            st_d.inc_int  = rate_int;
            st_d.inc_frac = rate_frac;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sec      <= '0;
            st_q.ns       <= '0;
            st_q.frac     <= '0;
            st_q.inc_int  <= INC_W'(RST_INC_NS);
            st_q.inc_frac <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tod_sec = st_q.sec;
    assign tod_ns  = st_q.ns;

    logic unused_kind;
    assign unused_kind = ^run_kind;
endmodule

// File: rtl/ptp_tod_clock_chk.sv
module ptp_tod_clock_chk #(
    parameter int SEC_W = 48,
    parameter int NS_W  = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             set_load,
    input logic [SEC_W-1:0] set_sec,
    input logic [NS_W-1:0]  set_ns,
    input logic             adj_load,
    input logic [SEC_W-1:0] tod_sec,
    input logic [NS_W-1:0]  tod_ns
);
    localparam logic [31:0] NPS = ptp_tod_pkg::NS_PER_SEC;

    AST_NS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tod_ns) < NPS); // R2

    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_load && 32'(set_ns) < NPS) |=>
        (tod_sec == $past(set_sec) && tod_ns == $past(set_ns))); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_load && adj_load && 32'(set_ns) < NPS) |=>
        (tod_ns == $past(set_ns))); // R7

    AST_SEC_HOLD_OR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_load && !adj_load) |=>
        (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 1'b1)); // R2

    AST_CARRY_FOLDS_NS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_load && !adj_load) |=>
        (tod_sec == $past(tod_sec) || tod_ns < $past(tod_ns))); // R2
endmodule

bind ptp_tod_clock ptp_tod_clock_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_load (set_load),
    .set_sec  (set_sec),
    .set_ns   (set_ns),
    .adj_load (adj_load),
    .tod_sec  (tod_sec),
    .tod_ns   (tod_ns)
);

// File: tb/sim_ptp_tod_clock.sv
`timescale 1ns/1ps
module sim_ptp_tod_clock;
    localparam longint NPS   = 64'd1_000_000_000;
    localparam longint SMASK = (64'd1 << 48) - 1;
    localparam longint FMASK = (64'd1 << 32) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               set_load = 1'b0;
    logic [47:0]        set_sec = '0;
    logic [29:0]        set_ns = '0;
    logic               adj_load = 1'b0;
    logic signed [29:0] adj_ns = '0;
    logic               rate_load = 1'b0;
    logic [3:0]         rate_int = '0;
    logic [31:0]        rate_frac = '0;
    logic [47:0]        tod_sec;
    logic [29:0]        tod_ns;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    longint m_sec, m_ns, m_frac, m_int, m_finc;

    always #2.5 clk = ~clk;

    ptp_tod_clock u0 (
        .clk(clk), .rst_n(rst_n),
        .set_load(set_load), .set_sec(set_sec), .set_ns(set_ns),
        .adj_load(adj_load), .adj_ns(adj_ns),
        .rate_load(rate_load), .rate_int(rate_int), .rate_frac(rate_frac),
        .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    task automatic check(string tag, longint es, longint en);
        checks++;
        if (tod_sec !== es[47:0] || tod_ns !== en[29:0]) begin
            failures++;
            $display("FAIL %s: actual %0d s %0d ns, expected %0d s %0d ns",
                     tag, tod_sec, tod_ns, es, en);
        end
    endtask

    function automatic void model_step();
        longint fsum, step, s;
        fsum = m_frac + m_finc;
        step = m_int + (fsum >> 32);
        if (set_load && longint'(set_ns) < NPS) begin
            m_sec  = longint'(set_sec);
            m_ns   = longint'(set_ns);
            m_frac = 0;
        end else begin
            s = m_ns + step + (adj_load ? longint'(adj_ns) : 64'sd0);
            if (s < 0) begin
                s = s + NPS; m_sec = (m_sec - 1) & SMASK;
            end else if (s >= NPS) begin
                s = s - NPS; m_sec = (m_sec + 1) & SMASK;
            end
            m_ns   = s;
            m_frac = fsum & FMASK;
        end
        if (rate_load) begin
            m_int  = longint'(rate_int);
            m_finc = longint'(rate_frac);
        end
    endfunction

    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, m_sec, m_ns);
        set_load = 1'b0; adj_load = 1'b0; rate_load = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sec = 0; m_ns = 0; m_frac = 0; m_int = 8; m_finc = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state", 0, 0);
        for (int k = 0; k < 10; k++) cyc("R1 nominal 8 ns");
        check("R1 80 ns after 10 clocks", 0, 80);

        set_load = 1'b1; set_sec = 48'd5; set_ns = 30'd999_999_990;
        cyc("R4 load near rollover");
        cyc("R2 before rollover");
        cyc("R2 rollover carry");
        check("R2 carried second", 6, 6);

        set_load = 1'b1; set_sec = '0; set_ns = '0;
        rate_load = 1'b1; rate_int = 4'd7; rate_frac = 32'h8000_0000;
        cyc("R8 load and rate together");
        for (int k = 0; k < 4; k++) cyc("R3 fractional step");
        check("R3 7.5 ns over 4 clocks", 0, 30);

        rate_load = 1'b1; rate_int = 4'd9; rate_frac = '0;
        cyc("R8 old rate on strobe clock");
        check("R8 strobe clock used 7.5", 0, 37);
        cyc("R8 new rate applies");
        check("R8 9 ns step", 0, 46);

        set_load = 1'b1; set_sec = 48'd77; set_ns = 30'd1_000_000_000;
        cyc("R5 out-of-range load ignored");
        check("R5 kept counting", 0, 55);

        rate_load = 1'b1; rate_int = 4'd8; rate_frac = '0;
        set_load = 1'b1; set_sec = 48'd10; set_ns = 30'd100;
        cyc("R4 load 10 s 100 ns");
        adj_load = 1'b1; adj_ns = -30'sd500;
        cyc("R6 negative offset borrow");
        check("R6 borrow result", 9, 999_999_608);
        adj_load = 1'b1; adj_ns = 30'sd400;
        cyc("R6 positive offset carry");
        check("R6 carry result", 10, 16);

        set_load = 1'b1; set_sec = 48'd3; set_ns = 30'd1234;
        adj_load = 1'b1; adj_ns = 30'sd5000;
        cyc("R7 load wins over offset");
        check("R7 offset discarded", 3, 1234);

        set_load = 1'b1; set_sec = 48'hFFFF_FFFF_FFFF; set_ns = 30'd999_999_990;
        cyc("R9 load max seconds");
        cyc("R9 before wrap");
        cyc("R9 wrap");
        check("R9 seconds wrapped", 0, 6);

        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(63) == 0) begin
                set_load = 1'b1;
                set_sec  = {$urandom(), $urandom()} >> 16;
                set_ns   = ($urandom_range(7) == 0) ? 30'(1_000_000_000 + $urandom_range(5))
                                                   : 30'($urandom_range(999_999_999));
            end
            if ($urandom_range(15) == 0) begin
                adj_load = 1'b1;
                adj_ns   = 30'($urandom());
            end
            if ($urandom_range(63) == 0) begin
                rate_load = 1'b1;
                rate_int  = 4'($urandom_range(9, 6));
                rate_frac = $urandom();
            end
            cyc("R3 R6 random steering");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule